// File: doc/BRIEF.md
# DRAM Row/Column Access Controller

This block sits between a simple word request port and a single-bank DRAM device that has multiplexed address pins. It accepts one read or write request at a time. For each request it drives the row half of the address with a row strobe and then the column half with a column strobe, on the same pins. The controller keeps the most recently opened row open. A later access to that row skips the precharge and row phases. An access to a different row closes the open row with a precharge first. A read returns a whole block of `BURST_LEN` words. The requested word comes first, and the column offset then wraps through the rest of the block.

A refresh timer raises a refresh request every `REF_INTERVAL` cycles. A refresh row counter steps through every row in turn, one row per refresh. A pending refresh is served as soon as the current sequence ends. It takes priority over any request waiting at the port. When `lp_req` is held high the controller enters a low-power state. In that state it takes no requests but still runs refreshes on schedule.

The state machine has seven states:
- `S_IDLE` waits for work.
- `S_PRE` closes the open row.
- `S_ACT` opens a row.
- `S_COL` issues one column strobe.
- `S_WAIT` counts the column latency.
- `S_REF` refreshes one row.
- `S_LOWPWR` holds off requests.

The transitions are:
- `S_IDLE` goes to `S_PRE` (refresh or miss with a row open), `S_REF` (refresh, no row open), `S_LOWPWR`, `S_COL` (open-row hit) or `S_ACT` (no row open).
- `S_PRE` goes to `S_REF` or `S_ACT`.
- `S_ACT` goes to `S_COL`.
- `S_COL` goes to `S_IDLE` (write) or `S_WAIT` (read).
- `S_WAIT` goes to `S_COL` (more beats) or `S_IDLE` (last beat).
- `S_REF` goes to `S_IDLE` or `S_LOWPWR`.
- `S_LOWPWR` goes to `S_PRE`, `S_REF` or `S_IDLE`.

Top module: `rowcol_ctrl`

## Requirements
- R1: The request address is `{row, column}`, each `HALF_W` bits wide. The row strobe cycle drives the row half on `dram_addr`. A column strobe cycle drives the column half on `dram_addr`, with its low `log2(BURST_LEN)` bits replaced by the current burst offset.
- R2: An access to the row that is already open issues column strobes only, with no precharge and no row strobe.
- R3: An access to a different row, with a row open, issues a precharge, then a row strobe at least `T_RP` cycles later, then a column strobe at least `T_RCD` cycles after the row strobe. At most one of precharge, row, column and refresh strobes is high in any cycle.
- R4: A read returns `BURST_LEN` responses. Response i carries the word at column offset `(start + i) mod BURST_LEN` within the block. `rsp_last` is high only on the final response.
- R5: Read data is the word the device presents `T_CL` cycles after the column strobe.
- R6: Each refresh pulses `dram_ref` with the refresh row on `dram_addr`. The first refresh after reset uses row 0, and each later refresh uses the previous row plus 1, modulo `2^HALF_W`. An open row is precharged before a refresh, and no row is open after it.
- R7: A refresh falls due every `REF_INTERVAL` cycles. It is served once the sequence in progress ends, ahead of any waiting request, so consecutive refreshes are never further apart than one interval plus one full access sequence.
- R8: While `lp_req` is high and the controller is in low power, no row or column strobe is issued and no request is accepted, yet refreshes continue.
- R9: `busy` is low only when the controller is idle, no refresh is pending and `lp_req` is low. A request is accepted in the cycle where `req_valid` is high and `busy` is low. After reset `busy` is low and no strobe or response is active.
- R10: A write issues one column strobe with `dram_we` high and the request data on `dram_wdata`, and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read burst |
| req_addr | input | 2*HALF_W | Word address, row half above column half |
| req_wdata | input | DATA_W | Write data |
| lp_req | input | 1 | Low-power request (level) |
| busy | output | 1 | Controller cannot accept a request |
| rsp_valid | output | 1 | Read data word valid |
| rsp_last | output | 1 | Final word of a read burst |
| rsp_rdata | output | DATA_W | Read data word |
| dram_addr | output | HALF_W | Multiplexed row/column/refresh address |
| dram_row_stb | output | 1 | Row strobe (open row) |
| dram_col_stb | output | 1 | Column strobe |
| dram_we | output | 1 | Column strobe is a write |
| dram_wdata | output | DATA_W | Write data to device |
| dram_pre | output | 1 | Precharge (close row) |
| dram_ref | output | 1 | Refresh one row |
| dram_rdata | input | DATA_W | Read data from device |

## Verification
The bench builds the block with `HALF_W`=6, `BURST_LEN`=4, `T_RCD`=`T_CL`=`T_RP`=2, `T_RFC`=3 and `REF_INTERVAL`=200. With only 64 rows, a full pass of the refresh counter and its wrap back to row 0 takes about 13,000 cycles. With a 200-cycle interval, refreshes land inside back-to-back burst traffic and inside a low-power window of a few hundred cycles. A start offset of 2 inside a 4-word block exercises the wrap of critical-word-first ordering. The short latencies keep each access near ten cycles, so a protocol-checking device model can test the precharge, row-to-column and latency spacing on every command.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_COL,
        S_WAIT,
        S_REF,
        S_LOWPWR
    } rc_state_e;
endpackage

// File: rtl/rc_delay.sv
// Loadable down-counter; done is high once the count reaches zero.
module rc_delay #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rc_refresh_timer.sv
// Interval timer raising a refresh request, plus the row counter it walks.
module rc_refresh_timer #(
    parameter int INTERVAL = 488,
    parameter int ROW_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             due,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = (cnt == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            due     <= 1'b0;
            ref_row <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (start) begin
                due     <= 1'b0;
                ref_row <= ref_row + 1'b1;
            end
            if (tick)
                due <= 1'b1;
        end
    end
endmodule

// File: rtl/rc_row_tracker.sv
// Remembers which row is open and compares a candidate row against it.
module rc_row_tracker #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row_in,
    input  logic             close_en,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (close_en) begin
            row_open <= 1'b0;
        end else if (open_en) begin
            row_open <= 1'b1;
            open_row <= open_row_in;
        end
    end

    assign hit = row_open && (open_row == cmp_row);
endmodule

// File: rtl/rowcol_ctrl.sv
module rowcol_ctrl
    import rc_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int DATA_W       = 32,
    parameter int BURST_LEN    = 4,
    parameter int T_RCD        = 3,
    parameter int T_CL         = 3,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 8,
    parameter int REF_INTERVAL = 488
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [2*HALF_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  lp_req,
    output logic                  busy,
    output logic                  rsp_valid,
    output logic                  rsp_last,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [HALF_W-1:0]     dram_addr,
    output logic                  dram_row_stb,
    output logic                  dram_col_stb,
    output logic                  dram_we,
    output logic [DATA_W-1:0]     dram_wdata,
    output logic                  dram_pre,
    output logic                  dram_ref,
    input  logic [DATA_W-1:0]     dram_rdata
);
    localparam int ADDR_W = 2 * HALF_W;
    localparam int BL_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int T_A    = (T_RCD > T_CL) ? T_RCD : T_CL;
    localparam int T_B    = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
    localparam int DLY_W  = $clog2(T_MAX + 1);

    rc_state_e state, state_nx;

    logic [HALF_W-1:0] lat_row, lat_col, cur_row, cur_col, ref_row, col_out;
    logic [DATA_W-1:0] lat_wdata, cur_wdata;
    logic              lat_we, cur_we, for_ref;
    logic [BL_W-1:0]   beat, nx_beat;
    logic              ref_due, row_open, hit, dly_done, enter, accept, last_beat;
    logic [DLY_W-1:0]  dly_val;

    // Request fields come straight from the port while idle, else from the latch.
    assign cur_row   = (state == S_IDLE) ? req_addr[ADDR_W-1:HALF_W] : lat_row;
    assign cur_col   = (state == S_IDLE) ? req_addr[HALF_W-1:0]      : lat_col;
    assign cur_we    = (state == S_IDLE) ? req_write : lat_we;
    assign cur_wdata = (state == S_IDLE) ? req_wdata : lat_wdata;

    assign busy      = (state != S_IDLE) || ref_due || lp_req;
    assign accept    = (state == S_IDLE) && req_valid && !busy;
    assign enter     = (state_nx != state);
    assign last_beat = (beat == BL_W'(BURST_LEN - 1));

    assign nx_beat = (state == S_WAIT) ? beat + 1'b1 :
                     (state == S_IDLE) ? '0 : beat;
    assign col_out = {cur_col[HALF_W-1:BL_W], cur_col[BL_W-1:0] + nx_beat};

    rc_refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(HALF_W)) u_ref_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (enter && state_nx == S_REF),
        .due     (ref_due),
        .ref_row (ref_row)
    );

    rc_row_tracker #(.ROW_W(HALF_W)) u_row_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_en     (enter && state_nx == S_ACT),
        .open_row_in (cur_row),
        .close_en    (enter && state_nx == S_PRE),
        .cmp_row     (cur_row),
        .row_open    (row_open),
        .hit         (hit)
    );

    always_comb begin
        unique case (state_nx)
            S_PRE:   dly_val = DLY_W'(T_RP - 1);
            S_ACT:   dly_val = DLY_W'(T_RCD - 1);
            S_WAIT:  dly_val = DLY_W'(T_CL - 1);
            S_REF:   dly_val = DLY_W'(T_RFC - 1);
            default: dly_val = '0;
        endcase
    end

    rc_delay #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter),
        .load_val (dly_val),
        .done     (dly_done)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (ref_due)         state_nx = row_open ? S_PRE : S_REF;
                else if (lp_req)     state_nx = S_LOWPWR;
                else if (req_valid)  state_nx = hit ? S_COL : (row_open ? S_PRE : S_ACT);
            end
            S_PRE:    if (dly_done) state_nx = for_ref ? S_REF : S_ACT;
            S_ACT:    if (dly_done) state_nx = S_COL;
            S_COL:    state_nx = cur_we ? S_IDLE : S_WAIT;
            S_WAIT:   if (dly_done) state_nx = last_beat ? S_IDLE : S_COL;
            S_REF:    if (dly_done) state_nx = lp_req ? S_LOWPWR : S_IDLE;
            S_LOWPWR: begin
                if (ref_due)         state_nx = row_open ? S_PRE : S_REF;
                else if (!lp_req)    state_nx = S_IDLE;
            end
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
            beat      <= '0;
            for_ref   <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE || state == S_LOWPWR)
                for_ref <= ref_due;
            if (accept) begin
                lat_row   <= cur_row;
                lat_col   <= cur_col;
                lat_we    <= req_write;
                lat_wdata <= req_wdata;
                beat      <= '0;
            end else if (state == S_WAIT && dly_done) begin
                beat <= beat + 1'b1;
            end
        end
    end

    // Registered outputs: strobes pulse in the first cycle of their state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_addr    <= '0;
            dram_row_stb <= 1'b0;
            dram_col_stb <= 1'b0;
            dram_we      <= 1'b0;
            dram_wdata   <= '0;
            dram_pre     <= 1'b0;
            dram_ref     <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_last     <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            dram_row_stb <= enter && (state_nx == S_ACT);
            dram_col_stb <= enter && (state_nx == S_COL);
            dram_pre     <= enter && (state_nx == S_PRE);
            dram_ref     <= enter && (state_nx == S_REF);
            dram_we      <= enter && (state_nx == S_COL) && cur_we;
            dram_wdata   <= (enter && state_nx == S_COL) ? cur_wdata : '0;
            if (enter && state_nx == S_ACT)      dram_addr <= cur_row;
            else if (enter && state_nx == S_COL) dram_addr <= col_out;
            else if (enter && state_nx == S_REF) dram_addr <= ref_row;
            else                                 dram_addr <= '0;
            rsp_valid <= (state == S_WAIT) && dly_done;
            rsp_last  <= (state == S_WAIT) && dly_done && last_beat;
            if (state == S_WAIT && dly_done)
                rsp_rdata <= dram_rdata;
        end
    end
endmodule

// File: rtl/rc_checker.sv
module rc_checker
    import rc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rc_state_e state,
    input logic      busy,
    input logic      dram_row_stb,
    input logic      dram_col_stb,
    input logic      dram_pre,
    input logic      dram_ref,
    input logic      row_open,
    input logic      rsp_valid,
    input logic      rsp_last
);
    // R3
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_row_stb, dram_col_stb, dram_pre, dram_ref}));

    // R3
    pre_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_pre |=> !dram_col_stb);

    // R2
    col_row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_col_stb |-> row_open);

    // R6
    ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ref |-> !row_open);

    // R8
    lowpwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOWPWR) |-> (!dram_row_stb && !dram_col_stb));

    // R9
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_row_stb || dram_col_stb || dram_pre || dram_ref) |-> busy);

    // R4
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);
endmodule

bind rowcol_ctrl rc_checker u_rc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .busy         (busy),
    .dram_row_stb (dram_row_stb),
    .dram_col_stb (dram_col_stb),
    .dram_pre     (dram_pre),
    .dram_ref     (dram_ref),
    .row_open     (row_open),
    .rsp_valid    (rsp_valid),
    .rsp_last     (rsp_last)
);

// File: tb/rowcol_ctrl_bench.sv
`timescale 1ns/1ps
module rowcol_ctrl_bench;
    localparam int HW   = 6;
    localparam int DW   = 16;
    localparam int BL   = 4;
    localparam int TRCD = 2;
    localparam int TCL  = 2;
    localparam int TRP  = 2;
    localparam int TRFC = 3;
    localparam int RINT = 200;
    localparam int NW   = 1 << (2 * HW);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, lp_req = 1'b0;
    logic [2*HW-1:0] req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic busy, rsp_valid, rsp_last;
    logic [DW-1:0] rsp_rdata, dram_wdata, dram_rdata;
    logic [HW-1:0] dram_addr;
    logic dram_row_stb, dram_col_stb, dram_we, dram_pre, dram_ref;

    always #2 clk = ~clk;

    rowcol_ctrl #(.HALF_W(HW), .DATA_W(DW), .BURST_LEN(BL), .T_RCD(TRCD),
                  .T_CL(TCL), .T_RP(TRP), .T_RFC(TRFC), .REF_INTERVAL(RINT))
    u_rowcol_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .lp_req(lp_req), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_row_stb(dram_row_stb), .dram_col_stb(dram_col_stb),
        .dram_we(dram_we), .dram_wdata(dram_wdata), .dram_pre(dram_pre),
        .dram_ref(dram_ref), .dram_rdata(dram_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(i * 37 + 5) ^ 16'h3C00;
    endfunction

    // Device model with protocol checks
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] exp_mem [NW];
    logic [DW-1:0] p0 = '0, p1 = '0;
    logic          m_open = 1'b0;
    logic [HW-1:0] m_row = '0;
    int since_pre = 1000, since_row = 1000, proto_err = 0;
    assign dram_rdata = p1;

    initial begin
        for (int i = 0; i < NW; i++) begin
            mem[i] = init_word(i);
            exp_mem[i] = init_word(i);
        end
    end

    always @(posedge clk) begin
        since_pre <= (since_pre < 1000) ? since_pre + 1 : since_pre;
        since_row <= (since_row < 1000) ? since_row + 1 : since_row;
        p1 <= p0;
        p0 <= 16'hDEAD;
        if (dram_pre) begin
            m_open <= 1'b0;
            since_pre <= 1;
        end
        if (dram_row_stb) begin
            if (m_open || since_pre < TRP) proto_err <= proto_err + 1;
            m_open <= 1'b1;
            m_row <= dram_addr;
            since_row <= 1;
        end
        if (dram_col_stb) begin
            if (!m_open || since_row < TRCD) proto_err <= proto_err + 1;
            if (dram_we) mem[{m_row, dram_addr}] <= dram_wdata;
            else         p0 <= mem[{m_row, dram_addr}];
        end
        if (dram_ref && m_open) proto_err <= proto_err + 1;
    end

    // Monitors, sampled at the falling edge
    int cyc = 0, n_row = 0, n_col = 0, n_pre = 0, n_ref = 0, n_we = 0, last_ref_cyc = 0;
    logic [HW-1:0] last_row_addr = '0, last_col_addr = '0, exp_ref_row = '0;
    logic [DW-1:0] last_wdata = '0;
    bit wrap_seen = 0;
    int rn = 0;
    logic [DW-1:0] rbuf [8];
    logic          rlast [8];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dram_row_stb) begin n_row++; last_row_addr = dram_addr; end
            if (dram_col_stb) begin
                n_col++; last_col_addr = dram_addr;
                if (dram_we) begin n_we++; last_wdata = dram_wdata; end
            end
            if (dram_pre) n_pre++;
            if (dram_ref) begin
                chk(dram_addr == exp_ref_row, "R6 refresh row", int'(dram_addr), int'(exp_ref_row));
                chk(cyc - last_ref_cyc <= RINT + 40, "R7 refresh gap", cyc - last_ref_cyc, RINT + 40);
                if (dram_addr == '0 && n_ref > 0) wrap_seen = 1;
                exp_ref_row = exp_ref_row + 1'b1;
                last_ref_cyc = cyc;
                n_ref++;
            end
            if (rsp_valid) begin
                if (rn < 8) begin rbuf[rn] = rsp_rdata; rlast[rn] = rsp_last; end
                rn++;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_req(input bit wr, input logic [HW-1:0] row,
                          input logic [HW-1:0] col, input logic [DW-1:0] d);
        wait_idle();
        req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) exp_mem[{row, col}] = d;
        while (busy) @(negedge clk);
    endtask

    task automatic sync_after_ref();
        int r0 = n_ref;
        while (n_ref == r0) @(negedge clk);
        wait_idle();
    endtask

    task automatic rd_check(input logic [HW-1:0] row, input logic [HW-1:0] col, input string tag);
        int guard = 0;
        rn = 0;
        do_req(1'b0, row, col, '0);
        while (rn < BL && guard < 200) begin @(negedge clk); guard++; end
        chk(rn == BL, {tag, " R4 beat count"}, rn, BL);
        for (int i = 0; i < BL; i++) begin
            logic [HW-1:0] c = {col[HW-1:2], 2'(col[1:0] + 2'(i))};
            chk(rbuf[i] == exp_mem[{row, c}], {tag, " R4 R5 read word"}, int'(rbuf[i]), int'(exp_mem[{row, c}]));
            chk(rlast[i] == (i == BL - 1), {tag, " R4 last flag"}, int'(rlast[i]), int'(i == BL - 1));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy after reset", busy, 0);
        chk(rsp_valid == 1'b0, "R9 no response after reset", rsp_valid, 0);
        chk(n_row + n_col + n_pre + n_ref == 0, "R9 no strobe after reset", n_row + n_col + n_pre + n_ref, 0);
    endtask

    task automatic t_write_row();
        int r0, c0, w0, p0c;
        sync_after_ref();
        r0 = n_row; c0 = n_col; w0 = n_we; p0c = n_pre; rn = 0;
        do_req(1'b1, 6'd5, 6'd8, 16'h1234);
        chk(last_row_addr == 6'd5, "R1 row half on row strobe", int'(last_row_addr), 5);
        chk(last_col_addr == 6'd8, "R1 column half on column strobe", int'(last_col_addr), 8);
        chk(last_wdata == 16'h1234, "R10 write data", int'(last_wdata), 16'h1234);
        for (int i = 9; i < 16; i++) do_req(1'b1, 6'd5, 6'(i), 16'(16'hA000 + i));
        chk(n_row - r0 == 1, "R2 one row strobe for same-row writes", n_row - r0, 1);
        chk(n_pre - p0c == 0, "R2 no precharge on hits", n_pre - p0c, 0);
        chk(n_we - w0 == 8 && n_col - c0 == 8, "R10 one write strobe per write", n_we - w0, 8);
        repeat (TCL + 3) @(negedge clk);
        chk(rn == 0, "R10 writes give no response", rn, 0);
    endtask

    task automatic t_read_crit();
        int r0;
        sync_after_ref();
        do_req(1'b1, 6'd5, 6'd8, 16'h0BAD);
        r0 = n_row;
        rd_check(6'd5, 6'd10, "crit-word-first");
        chk(n_row == r0, "R2 read hit has no row strobe", n_row - r0, 0);
        rd_check(6'd5, 6'd15, "offset3");
    endtask

    task automatic t_row_miss();
        int r0, p0c;
        sync_after_ref();
        do_req(1'b1, 6'd5, 6'd0, 16'h5555);
        r0 = n_row; p0c = n_pre;
        do_req(1'b1, 6'd9, 6'd3, 16'h9999);
        chk(n_pre - p0c == 1, "R3 precharge on row miss", n_pre - p0c, 1);
        chk(n_row - r0 == 1, "R3 row strobe on row miss", n_row - r0, 1);
        chk(last_row_addr == 6'd9, "R1 new row address", int'(last_row_addr), 9);
        rd_check(6'd9, 6'd1, "miss-read");
        rd_check(6'd5, 6'd12, "miss-back");
        chk(proto_err == 0, "R3 device timing and ordering", proto_err, 0);
    endtask

    task automatic t_ref_close();
        int r0, p0c;
        do_req(1'b1, 6'd5, 6'd1, 16'h7777);
        sync_after_ref();
        r0 = n_row; p0c = n_pre;
        rd_check(6'd5, 6'd0, "after-refresh");
        chk(n_row - r0 == 1, "R6 refresh leaves no row open", n_row - r0, 1);
        chk(n_pre - p0c == 0, "R6 no extra precharge after refresh", n_pre - p0c, 0);
    endtask

    task automatic t_lowpwr();
        int r0, c0, f0;
        wait_idle();
        lp_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = {6'd3, 6'd3}; req_wdata = 16'hFFFF;
        r0 = n_row; c0 = n_col; f0 = n_ref; rn = 0;
        repeat (3 * RINT) @(negedge clk);
        chk(busy == 1'b1, "R9 busy in low power", busy, 1);
        chk(n_row - r0 == 0 && n_col - c0 == 0, "R8 no access in low power", n_row - r0 + n_col - c0, 0);
        chk(n_ref - f0 >= 2, "R8 refresh continues in low power", n_ref - f0, 2);
        req_valid = 1'b0; lp_req = 1'b0;
        rd_check(6'd3, 6'd2, "after-lowpower");
        chk(rbuf[1] == init_word({6'd3, 6'd3}), "R8 held write was ignored", int'(rbuf[1]), int'(init_word({6'd3, 6'd3})));
    endtask

    task automatic t_preempt();
        int f0 = n_ref;
        for (int k = 0; k < 40; k++)
            rd_check(6'(k % 3 + 20), 6'(k * 5), "R7 traffic");
        chk(n_ref - f0 >= 2, "R7 refresh served during traffic", n_ref - f0, 2);
    endtask

    task automatic t_ref_wrap();
        int guard = 0;
        lp_req = 1'b1;
        while (n_ref < (1 << HW) + 2 && guard < 20000) begin @(negedge clk); guard++; end
        lp_req = 1'b0;
        chk(wrap_seen, "R6 refresh row wraps to 0", int'(wrap_seen), 1);
        chk(proto_err == 0, "R3 R6 device protocol", proto_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_row();
        t_read_crit();
        t_row_miss();
        t_ref_close();
        t_lowpwr();
        t_preempt();
        t_ref_wrap();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule